// File: doc/BRIEF.md
# Event-Triggered Byte-Range Fetch for One Port

This block serves one port of a module-management controller. It watches three slow status lines from the port. When the chosen edge appears on the chosen line, it reads a configured run of bytes from the remote device, one byte at a time, through a request/response port to a serial bus master. The bytes are kept in a small local store. When the whole run arrives without a refusal, the block drives an active-low interrupt and sets the port's summary flag. It then takes no further action until a re-arm write comes in.

A host read lookup port answers the question "can this byte be served locally?". The block combines its own store with the answer from the periodic cache, which sits outside the block. Wherever the two overlap, its own bytes win. If neither cache holds the byte, the lookup reports a miss, so the read goes on to the remote device.

Top module: `evf_prefetch_port`

## Requirements
- R1: After reset, `host_int_n_o` is 1, `port_flag_o` is 0 and `rd_req_o` is 0, and a lookup with `per_hit_i` low reports a miss (hit 0, data 0).
- R2: A fetch starts with `rd_req_o` high. It requests `cfg_offset_i`, then each following address (modulo 256), and makes `cfg_len_m1_i`+1 requests in all. The device address is 0xA0 when `cfg_dev_sel_i` is 0 and 0xA2 when it is 1. A pending request holds its address until `rd_ack_i` or `rd_nack_i`.
- R3: Only the line numbered by `cfg_sel_i` (0 to 2) can trigger. It triggers on a rising edge when `cfg_rising_i` is 1 and on a falling edge when it is 0. A value of 3 in `cfg_sel_i` disables triggering.
- R4: One cycle after the last byte is acknowledged, `host_int_n_o` goes to 0, `port_flag_o` goes to 1 and `rd_req_o` goes to 0.
- R5: After a successful fetch, edges start no fetch, and the interrupt stays active until `rearm_i` is pulsed. The pulse clears the interrupt and the flag one cycle later, and it lets the next edge start a new fetch.
- R6: When a request is refused (`rd_nack_i`), the fetch ends without an interrupt. Its range then reports a miss. The block stays armed, so the next edge fetches again without a re-arm.
- R7: A lookup of the stored device address at an address inside the fetched range gives, two cycles later, `lk_rsp_valid_o`=1 and hit=1 with the fetched byte. The range and device are captured when the fetch starts. The store stays valid across a re-arm until the next fetch starts.
- R8: When both this store and the periodic cache (`per_hit_i`) hold the address, the response carries this block's byte.
- R9: Outside this block's range, a periodic hit returns `per_data_i`. With no periodic hit, the lookup misses.
- R10: Edges on the selected line while a fetch is in progress are dropped. They do not start a fetch after that fetch ends.
- R11: Lengths from 1 to 32 bytes are supported, and both limits work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 3 | Slow status lines from the port |
| cfg_sel_i | input | 2 | Trigger line number; 3 disables |
| cfg_rising_i | input | 1 | 1 = rising edge, 0 = falling edge |
| cfg_offset_i | input | 8 | First byte address of the fetch |
| cfg_len_m1_i | input | 5 | Fetch length minus one |
| cfg_dev_sel_i | input | 1 | Remote device select: 0 gives 0xA0, 1 gives 0xA2 |
| rearm_i | input | 1 | Re-arm write pulse; clears the interrupt |
| rd_req_o | output | 1 | Byte read request to the bus master |
| rd_dev_addr_o | output | 8 | Device address of the request |
| rd_addr_o | output | 8 | Byte address of the request |
| rd_ack_i | input | 1 | Byte returned (one-cycle pulse) |
| rd_nack_i | input | 1 | Request refused (one-cycle pulse) |
| rd_data_i | input | 8 | Returned byte, valid with `rd_ack_i` |
| host_int_n_o | output | 1 | Active-low interrupt |
| port_flag_o | output | 1 | Port summary interrupt flag |
| lk_valid_i | input | 1 | Lookup request |
| lk_dev_addr_i | input | 8 | Lookup device address |
| lk_addr_i | input | 8 | Lookup byte address |
| per_hit_i | input | 1 | Periodic cache hit, one cycle after the lookup |
| per_data_i | input | 8 | Periodic cache byte, with `per_hit_i` |
| lk_rsp_valid_o | output | 1 | Lookup response valid |
| lk_rsp_hit_o | output | 1 | Byte can be served locally |
| lk_rsp_data_o | output | 8 | Byte served locally (0 on a miss) |

## Verification
The assertions assume that the bus master pulses `rd_ack_i` or `rd_nack_i` for exactly one cycle, never both at once, and only while `rd_req_o` is high. They also assume that the periodic cache answers one cycle after the lookup. The bench's remote model answers each request after a fixed delay with a single pulse of one kind. The lookup driver holds `per_hit_i`/`per_data_i` steady through the cycle after each lookup and issues lookups one at a time.

// File: rtl/evf_pkg.sv
package evf_pkg;
  localparam int DEV_W = 8;
  localparam logic [DEV_W-1:0] DEV_ADDR_LO = 8'hA0;
  localparam logic [DEV_W-1:0] DEV_ADDR_HI = 8'hA2;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_FETCH = 2'd1,
    ST_HELD  = 2'd2
  } fetch_st_t;
endpackage

// File: rtl/evf_line_sync.sv
module evf_line_sync #(
  parameter int N_LINES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] rise_o,
  output logic [N_LINES-1:0] fall_o
);
  logic [N_LINES-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/evf_store.sv
module evf_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/evf_seq.sv
module evf_seq
  import evf_pkg::*;
#(
  parameter int N_LINES = 3,
  parameter int ADDR_W  = 8,
  parameter int MAX_LEN = 32,
  localparam int LEN_W  = $clog2(MAX_LEN),
  localparam int SEL_W  = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] rise_i,
  input  logic [N_LINES-1:0] fall_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic               cfg_rising_i,
  input  logic [ADDR_W-1:0]  cfg_offset_i,
  input  logic [LEN_W-1:0]   cfg_len_m1_i,
  input  logic               cfg_dev_sel_i,
  input  logic               rearm_i,
  input  logic               rd_ack_i,
  input  logic               rd_nack_i,
  output logic               rd_req_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic               wr_en_o,
  output logic [LEN_W-1:0]   wr_idx_o,
  output logic [ADDR_W-1:0]  base_o,
  output logic [LEN_W-1:0]   last_o,
  output logic               dev_sel_o,
  output logic               valid_o,
  output logic               irq_o
);
  fetch_st_t        st_q;
  logic [LEN_W-1:0] idx_q;
  logic             trig;

  always_comb begin
    trig = 1'b0;
    for (int i = 0; i < N_LINES; i++) begin
      if (cfg_sel_i == SEL_W'(i))
        trig = cfg_rising_i ? rise_i[i] : fall_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_ARMED;
      idx_q     <= '0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      base_o    <= '0;
      last_o    <= '0;
      dev_sel_o <= 1'b0;
      valid_o   <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      if (rearm_i) irq_o <= 1'b0;
      unique case (st_q)
        ST_ARMED: begin
          if (trig) begin
            base_o    <= cfg_offset_i;
            last_o    <= cfg_len_m1_i;
            dev_sel_o <= cfg_dev_sel_i;
            rd_addr_o <= cfg_offset_i;
            valid_o   <= 1'b0;
            idx_q     <= '0;
            rd_req_o  <= 1'b1;
            st_q      <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (rd_ack_i) begin
            if (idx_q == last_o) begin
              rd_req_o <= 1'b0;
              valid_o  <= 1'b1;
              irq_o    <= 1'b1;
              st_q     <= ST_HELD;
            end else begin
              idx_q     <= idx_q + 1'b1;
              rd_addr_o <= rd_addr_o + 1'b1;
            end
          end else if (rd_nack_i) begin
            rd_req_o <= 1'b0;
            st_q     <= ST_ARMED;
          end
        end
        ST_HELD: begin
          if (rearm_i) st_q <= ST_ARMED;
        end
        default: st_q <= ST_ARMED;
      endcase
    end
  end

  assign wr_en_o  = (st_q == ST_FETCH) && rd_ack_i;
  assign wr_idx_o = idx_q;

  // R2: an unanswered request keeps its address
  a_r2_req_stable: assert property (@(posedge clk) disable iff (rst)
    rd_req_o && !rd_ack_i && !rd_nack_i |=> rd_req_o && $stable(rd_addr_o));
  // R2: the bus master answers only a live request, and with one kind of pulse
  a_r2_answer_legal: assert property (@(posedge clk) disable iff (rst)
    (rd_ack_i || rd_nack_i) |-> rd_req_o && !(rd_ack_i && rd_nack_i));
  // R4: the last acknowledged byte raises the interrupt and validates the store
  a_r4_done_irq: assert property (@(posedge clk) disable iff (rst)
    rd_req_o && rd_ack_i && idx_q == last_o |=> irq_o && valid_o && !rd_req_o);
  // R5: while held, nothing is requested until the re-arm
  a_r5_held_quiet: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_HELD && !rearm_i |=> !rd_req_o && irq_o);
  // R6: a refusal leaves the block armed, without an interrupt
  a_r6_nack_clean: assert property (@(posedge clk) disable iff (rst)
    rd_req_o && rd_nack_i && !rd_ack_i |=> !rd_req_o && !irq_o && !valid_o && st_q == ST_ARMED);
  // R3: a disabled selection never starts a fetch
  a_r3_off_no_start: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_ARMED && cfg_sel_i >= SEL_W'(N_LINES) |=> !rd_req_o);
endmodule

// File: rtl/evf_prefetch_port.sv
module evf_prefetch_port
  import evf_pkg::*;
#(
  parameter int N_LINES = 3,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 32,
  localparam int LEN_W  = $clog2(MAX_LEN),
  localparam int SEL_W  = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] line_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic               cfg_rising_i,
  input  logic [ADDR_W-1:0]  cfg_offset_i,
  input  logic [LEN_W-1:0]   cfg_len_m1_i,
  input  logic               cfg_dev_sel_i,
  input  logic               rearm_i,
  output logic               rd_req_o,
  output logic [DEV_W-1:0]   rd_dev_addr_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic               rd_ack_i,
  input  logic               rd_nack_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               host_int_n_o,
  output logic               port_flag_o,
  input  logic               lk_valid_i,
  input  logic [DEV_W-1:0]   lk_dev_addr_i,
  input  logic [ADDR_W-1:0]  lk_addr_i,
  input  logic               per_hit_i,
  input  logic [DATA_W-1:0]  per_data_i,
  output logic               lk_rsp_valid_o,
  output logic               lk_rsp_hit_o,
  output logic [DATA_W-1:0]  lk_rsp_data_o
);
  logic [N_LINES-1:0] rise, fall;
  logic               wr_en, dev_sel, valid, irq;
  logic [LEN_W-1:0]   wr_idx, last;
  logic [ADDR_W-1:0]  base, diff;
  logic [DATA_W-1:0]  ram_q;
  logic [DEV_W-1:0]   dev_addr;
  logic               hit_c, s1_v, s1_hit;

  evf_line_sync #(.N_LINES(N_LINES)) i_sync (
    .clk(clk), .rst(rst), .line_i(line_i), .rise_o(rise), .fall_o(fall)
  );

  evf_seq #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) i_seq (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall),
    .cfg_sel_i(cfg_sel_i), .cfg_rising_i(cfg_rising_i),
    .cfg_offset_i(cfg_offset_i), .cfg_len_m1_i(cfg_len_m1_i),
    .cfg_dev_sel_i(cfg_dev_sel_i), .rearm_i(rearm_i),
    .rd_ack_i(rd_ack_i), .rd_nack_i(rd_nack_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .base_o(base), .last_o(last),
    .dev_sel_o(dev_sel), .valid_o(valid), .irq_o(irq)
  );

  assign dev_addr      = dev_sel ? DEV_ADDR_HI : DEV_ADDR_LO;
  assign rd_dev_addr_o = dev_addr;
  assign host_int_n_o  = ~irq;
  assign port_flag_o   = irq;

  // Offset of the lookup inside the captured range (wraps like the fetch)
  assign diff  = lk_addr_i - base;
  assign hit_c = valid && (lk_dev_addr_i == dev_addr) && (diff <= ADDR_W'(last));

  evf_store #(.DEPTH(MAX_LEN), .DATA_W(DATA_W)) i_store (
    .clk(clk), .we_i(wr_en), .waddr_i(wr_idx), .wdata_i(rd_data_i),
    .raddr_i(diff[LEN_W-1:0]), .rdata_o(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v           <= 1'b0;
      s1_hit         <= 1'b0;
      lk_rsp_valid_o <= 1'b0;
      lk_rsp_hit_o   <= 1'b0;
      lk_rsp_data_o  <= '0;
    end else begin
      s1_v           <= lk_valid_i;
      s1_hit         <= lk_valid_i && hit_c;
      lk_rsp_valid_o <= s1_v;
      if (s1_hit) begin
        lk_rsp_hit_o  <= 1'b1;
        lk_rsp_data_o <= ram_q;
      end else begin
        lk_rsp_hit_o  <= per_hit_i;
        lk_rsp_data_o <= per_hit_i ? per_data_i : '0;
      end
    end
  end

  // R7: a lookup is answered exactly two cycles later
  a_r7_stage1: assert property (@(posedge clk) disable iff (rst) lk_valid_i |=> s1_v);
  a_r7_stage2: assert property (@(posedge clk) disable iff (rst) s1_v |=> lk_rsp_valid_o);
  // R8: a local hit is served locally whatever the periodic cache says
  a_r8_local_wins: assert property (@(posedge clk) disable iff (rst)
    s1_v && s1_hit |=> lk_rsp_valid_o && lk_rsp_hit_o);
  // R9: no cache holding the byte means a miss with zero data
  a_r9_miss: assert property (@(posedge clk) disable iff (rst)
    s1_v && !s1_hit && !per_hit_i |=> !lk_rsp_hit_o && lk_rsp_data_o == '0);
  // R4: the interrupt pin and the flag always agree
  a_r4_pin_flag: assert property (@(posedge clk) disable iff (rst)
    host_int_n_o == !port_flag_o);
endmodule

// File: tb/test_evf_prefetch_port.sv
`timescale 1ns/1ps
module test_evf_prefetch_port;
  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] line = '0;
  logic [1:0] cfg_sel = 2'd3;
  logic       cfg_rising = 1;
  logic [7:0] cfg_offset = '0;
  logic [4:0] cfg_len_m1 = '0;
  logic       cfg_dev_sel = 0;
  logic       rearm = 0;
  logic       rd_req, rd_ack, rd_nack;
  logic [7:0] rd_dev_addr, rd_addr, rd_data;
  logic       host_int_n, port_flag;
  logic       lk_valid = 0;
  logic [7:0] lk_dev = '0, lk_addr = '0;
  logic       per_hit = 0;
  logic [7:0] per_data = '0;
  logic       rsp_valid, rsp_hit;
  logic [7:0] rsp_data;

  always #2.5 clk = ~clk;

  evf_prefetch_port i_evf_prefetch_port (
    .clk(clk), .rst(rst), .line_i(line), .cfg_sel_i(cfg_sel),
    .cfg_rising_i(cfg_rising), .cfg_offset_i(cfg_offset),
    .cfg_len_m1_i(cfg_len_m1), .cfg_dev_sel_i(cfg_dev_sel), .rearm_i(rearm),
    .rd_req_o(rd_req), .rd_dev_addr_o(rd_dev_addr), .rd_addr_o(rd_addr),
    .rd_ack_i(rd_ack), .rd_nack_i(rd_nack), .rd_data_i(rd_data),
    .host_int_n_o(host_int_n), .port_flag_o(port_flag),
    .lk_valid_i(lk_valid), .lk_dev_addr_i(lk_dev), .lk_addr_i(lk_addr),
    .per_hit_i(per_hit), .per_data_i(per_data),
    .lk_rsp_valid_o(rsp_valid), .lk_rsp_hit_o(rsp_hit), .lk_rsp_data_o(rsp_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rmt(input logic [7:0] dev, input logic [7:0] a);
    return a ^ dev ^ 8'h3C;
  endfunction

  // Remote device model: answers each request three cycles after it is seen
  int served = 0, reqcyc = 0, lat = 0, nack_idx = 0;
  bit nack_en = 0, nack_seen = 0;
  logic [7:0] first_addr = '0, last_addr = '0, last_dev = '0;
  initial begin
    rd_ack = 0; rd_nack = 0; rd_data = '0;
    forever begin
      @(negedge clk);
      rd_ack = 0; rd_nack = 0;
      if (rd_req && !rst) begin
        reqcyc++;
        lat++;
        if (lat == 3) begin
          lat = 0;
          if (nack_en && served == nack_idx) begin
            rd_nack = 1; nack_seen = 1; nack_en = 0;
          end else begin
            rd_ack = 1;
            rd_data = rmt(rd_dev_addr, rd_addr);
            if (served == 0) first_addr = rd_addr;
            last_addr = rd_addr;
            last_dev = rd_dev_addr;
            served++;
          end
        end
      end else lat = 0;
    end
  end

  // Lookup scoreboard
  logic [8:0] exp_q[$];
  string      tag_q[$];
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid && !rst) begin
        if (exp_q.size() == 0) chk("R7 unexpected response", 1, 0);
        else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " hit"}, int'(rsp_hit), int'(e[8]));
          chk({t, " data"}, int'(rsp_data), int'(e[7:0]));
        end
      end
    end
  end

  task automatic look(input logic [7:0] dev, input logic [7:0] a, input bit ph,
                      input logic [7:0] pd, input bit ehit, input logic [7:0] edat,
                      input string tag);
    exp_q.push_back({ehit, edat});
    tag_q.push_back(tag);
    @(negedge clk);
    lk_valid = 1; lk_dev = dev; lk_addr = a; per_hit = ph; per_data = pd;
    @(negedge clk);
    lk_valid = 0;
    @(negedge clk);
    @(negedge clk);
    per_hit = 0;
  endtask

  task automatic set_line(input int i, input logic v);
    @(negedge clk);
    line[i] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input string tag);
    int k = 0;
    while (host_int_n && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " interrupt reached"}, int'(host_int_n), 0);
  endtask

  task automatic do_rearm();
    @(negedge clk); rearm = 1;
    @(negedge clk); rearm = 0;
  endtask

  task automatic finish_run();
    chk("R7 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r0;
    idle(3);
    rst = 0;
    idle(2);
    // R1 reset state
    chk("R1 int_n", int'(host_int_n), 1);
    chk("R1 flag", int'(port_flag), 0);
    chk("R1 rd_req", int'(rd_req), 0);
    look(8'hA0, 8'h10, 0, 8'h00, 0, 8'h00, "R1 lookup miss");

    // R3: an edge on a line that is not selected does nothing
    cfg_sel = 2'd1; cfg_rising = 1; cfg_offset = 8'h10; cfg_len_m1 = 5'd3; cfg_dev_sel = 0;
    set_line(0, 1);
    idle(20);
    chk("R3 unselected line", reqcyc, 0);
    // R2 / R4: rising edge on line 1 fetches four bytes
    served = 0;
    set_line(1, 1);
    wait_irq("R4");
    chk("R2 byte count", served, 4);
    chk("R2 first addr", int'(first_addr), 8'h10);
    chk("R2 last addr", int'(last_addr), 8'h13);
    chk("R2 device", int'(last_dev), 8'hA0);
    chk("R4 flag", int'(port_flag), 1);
    chk("R4 rd_req low", int'(rd_req), 0);

    // R7 / R8 / R9 lookups
    look(8'hA0, 8'h10, 0, 8'h00, 1, rmt(8'hA0, 8'h10), "R7 low end");
    look(8'hA0, 8'h13, 0, 8'h00, 1, rmt(8'hA0, 8'h13), "R7 high end");
    look(8'hA0, 8'h14, 0, 8'h00, 0, 8'h00, "R9 above range");
    look(8'hA0, 8'h0F, 0, 8'h00, 0, 8'h00, "R9 below range");
    look(8'hA2, 8'h11, 0, 8'h00, 0, 8'h00, "R7 other device");
    look(8'hA0, 8'h11, 1, 8'hEE, 1, rmt(8'hA0, 8'h11), "R8 overlap");
    look(8'hA0, 8'h20, 1, 8'hEE, 1, 8'hEE, "R9 periodic only");

    // R5: disarmed, edges ignored, interrupt held
    r0 = reqcyc;
    set_line(1, 0);
    idle(4);
    set_line(1, 1);
    idle(20);
    chk("R5 no fetch while held", reqcyc, r0);
    chk("R5 int held", int'(host_int_n), 0);
    do_rearm();
    chk("R5 int cleared", int'(host_int_n), 1);
    chk("R5 flag cleared", int'(port_flag), 0);
    look(8'hA0, 8'h12, 0, 8'h00, 1, rmt(8'hA0, 8'h12), "R7 kept after rearm");

    // R3 falling edge, R11 length 1, R2 second device
    cfg_rising = 0; cfg_dev_sel = 1; cfg_offset = 8'h40; cfg_len_m1 = 5'd0;
    served = 0;
    set_line(1, 0);
    wait_irq("R3 falling");
    chk("R11 one byte", served, 1);
    chk("R2 addr len1", int'(first_addr), 8'h40);
    chk("R2 device hi", int'(last_dev), 8'hA2);
    look(8'hA2, 8'h40, 0, 8'h00, 1, rmt(8'hA2, 8'h40), "R11 len1 hit");
    look(8'hA2, 8'h41, 0, 8'h00, 0, 8'h00, "R11 len1 edge");
    look(8'hA0, 8'h10, 0, 8'h00, 0, 8'h00, "R7 old range replaced");
    do_rearm();

    // R3: selection 3 disables every line
    cfg_sel = 2'd3; cfg_rising = 1;
    r0 = reqcyc;
    for (int i = 0; i < 3; i++) begin
      set_line(i, ~line[i]);
      idle(3);
      set_line(i, ~line[i]);
      idle(3);
    end
    idle(20);
    chk("R3 disabled", reqcyc, r0);
    chk("R3 no int", int'(host_int_n), 1);

    // R6 / R10: refusal mid-fetch with an edge during the fetch
    cfg_sel = 2'd2; cfg_rising = 1; cfg_offset = 8'h80; cfg_len_m1 = 5'd31; cfg_dev_sel = 0;
    served = 0; nack_idx = 5; nack_en = 1; nack_seen = 0;
    set_line(2, 1);
    idle(5);
    set_line(2, 0);
    idle(5);
    set_line(2, 1);
    for (int k = 0; k < 500 && !nack_seen; k++) @(negedge clk);
    idle(2);
    r0 = reqcyc;
    idle(25);
    chk("R10 no late fetch", reqcyc, r0);
    chk("R6 bytes before refusal", served, 5);
    chk("R6 no int", int'(host_int_n), 1);
    chk("R6 no flag", int'(port_flag), 0);
    look(8'hA0, 8'h80, 0, 8'h00, 0, 8'h00, "R6 range misses");

    // R6 still armed, R11 full length 32
    served = 0;
    set_line(2, 0);
    idle(4);
    set_line(2, 1);
    wait_irq("R6 armed");
    chk("R11 32 bytes", served, 32);
    chk("R11 first", int'(first_addr), 8'h80);
    chk("R11 last", int'(last_addr), 8'h9F);
    look(8'hA0, 8'h9F, 0, 8'h00, 1, rmt(8'hA0, 8'h9F), "R11 last byte hit");
    look(8'hA0, 8'hA0, 0, 8'h00, 0, 8'h00, "R11 past end miss");
    look(8'hA0, 8'h90, 1, 8'h55, 1, rmt(8'hA0, 8'h90), "R8 overlap newer periodic");
    look(8'hA0, 8'h7F, 1, 8'h55, 1, 8'h55, "R9 periodic below");
    idle(5);
    done_flag = 1;
    finish_run();
  end
endmodule